// File: doc/BRIEF.md
# Fractional-Divider PWM Time Base

This block is the time base of a PWM channel. A fractional clock divider turns the source clock into count ticks. Each tick advances an up-counter whose width can be set at run time, and the counter wraps to zero at the end of every PWM period. The divisor is a fixed-point number with an 8-bit fraction. When the fraction is not zero, each tick interval is the integer part or the integer part plus one source clocks, chosen so that the long-run average is divisor/256 clocks.

Software writes all control fields together with one write strobe. New divisor and resolution values are held in a shadow register. They become active only after the write also sets the update bit. The update bit clears itself when the new values take effect, which is at the next counter wrap, or within two clocks while the timer is held. A hold bit keeps the count at zero, and a pause bit freezes the count in place.

A three-state controller sets the timer's activity. The states are TMR_HOLD (counter cleared, divider cleared, pending update applied), TMR_RUN (divider and counter advance) and TMR_PAUSE (everything frozen). Its transitions are:
- HOLD_TO_RUN: hold cleared with pause clear.
- HOLD_TO_PAUSE: hold cleared with pause set.
- RUN_TO_PAUSE: pause set.
- PAUSE_TO_RUN: pause cleared.
- RUN_TO_HOLD and PAUSE_TO_HOLD: hold set.

Hold takes priority over pause.

Top module: `pwm_frac_timer`

## Requirements
- R1: After synchronous reset, `cnt_o` reads 0, `ovf_o` is low, `upd_pend_o` is low, and the hold bit is set, so the count stays at 0 until a write clears hold.
- R2: With a zero fraction (`cfg_div[7:0]` = 0) and an integer part I = `cfg_div[17:8]` of 1 or more, the count advances once every I clocks.
- R3: With a fraction F = `cfg_div[7:0]`, an 8-bit accumulator starts at 0 when the timer leaves hold or applies an update. F is added to it at each tick, and the carry out of that addition lengthens the next tick interval to I+1 clocks. The first interval has no extra clock.
- R4: An integer part of 0 is treated as 1.
- R5: The counter counts 0, 1, ..., 2^res−1 and then 0 again, where res = `cfg_res`. A res of 0 is treated as 1, and a res above 20 is treated as 20.
- R6: `ovf_o` is high for exactly one clock, in the clock where the count first reads 0 after a wrap, and is never high at any other time.
- R7: A write with `cfg_upd`=1 raises `upd_pend_o` in the next clock. The new divisor and resolution take effect at the next counter wrap, and `upd_pend_o` falls at that same edge, when the count reads 0 and `ovf_o` is high.
- R8: A write of divisor and resolution with `cfg_upd`=0 leaves the active period and tick rate unchanged.
- R9: A write with `cfg_hold`=1 makes `cnt_o` read 0 from the next clock for as long as hold stays set. A pending update is applied within two clocks while held.
- R10: A write with `cfg_pause`=1 freezes the count. Clearing pause resumes counting from the frozen value, and the next value is that value plus one, modulo the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe; samples every cfg_* field |
| cfg_div | input | 18 | Divisor, upper 10 bits integer, lower 8 bits fraction |
| cfg_res | input | 5 | Counter resolution in bits |
| cfg_pause | input | 1 | Pause bit value |
| cfg_hold | input | 1 | Hold (counter clear) bit value |
| cfg_upd | input | 1 | Request to apply divisor and resolution |
| cnt_o | output | 20 | Current count |
| ovf_o | output | 1 | One-clock pulse at each wrap |
| upd_pend_o | output | 1 | Update bit readback; high while an update waits |

## Verification
A corrupted accumulator or a divider counter that is not cleared shows up within one or two ticks as an interval of the wrong length between count changes. The scoreboard measures the length of every interval. A wrong state in the controller, or a counter mask that does not match the latched resolution, makes the value sequence skip a step or wrap at the wrong point. This is caught at the first change after it happens. An update applied at the wrong moment leaves `upd_pend_o` falling while the count is not zero, or leaves the old interval in use after the wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        TMR_HOLD  = 2'd0,
        TMR_RUN   = 2'd1,
        TMR_PAUSE = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/pwm_cfg_shadow.sv
module pwm_cfg_shadow #(
    parameter int DIV_W  = 18,
    parameter int FRAC_W = 8,
    parameter int RES_W  = 5,
    parameter int CNT_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [RES_W-1:0] wr_res,
    input  logic             wr_pause,
    input  logic             wr_hold,
    input  logic             wr_upd,
    input  logic             latch_ok,
    output logic             pause_q,
    output logic             hold_q,
    output logic             upd_pend_q,
    output logic [DIV_W-1:0] act_div,
    output logic [RES_W-1:0] act_res,
    output logic             applied
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1) << FRAC_W;
    localparam logic [RES_W-1:0] RES_MIN = RES_W'(1);
    localparam logic [RES_W-1:0] RES_MAX = RES_W'(CNT_W);

    logic [DIV_W-1:0] pend_div;
    logic [RES_W-1:0] pend_res;

    // Resolution is kept legal when it is written, so the active value never needs checking.
    function automatic logic [RES_W-1:0] clamp_res(input logic [RES_W-1:0] r);
        if (r == '0)         return RES_MIN;
        else if (r > RES_MAX) return RES_MAX;
        else                  return r;
    endfunction

    assign applied = latch_ok & upd_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_q    <= 1'b0;
            hold_q     <= 1'b1;
            upd_pend_q <= 1'b0;
            pend_div   <= DIV_ONE;
            pend_res   <= RES_MIN;
            act_div    <= DIV_ONE;
            act_res    <= RES_MIN;
        end else begin
            if (we) begin
                pause_q  <= wr_pause;
                hold_q   <= wr_hold;
                pend_div <= wr_div;
                pend_res <= clamp_res(wr_res);
            end
            if (applied) begin
                act_div <= pend_div;
                act_res <= pend_res;
            end
            upd_pend_q <= (upd_pend_q & ~applied) | (we & wr_upd);
        end
    end

endmodule

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
    parameter int DIV_W  = 18,
    parameter int FRAC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int INT_W = DIV_W - FRAC_W;
    localparam int LEN_W = INT_W + 1;

    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic [LEN_W-1:0]  int_eff;
    logic [LEN_W-1:0]  target;
    logic [LEN_W-1:0]  div_cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic              extra;

    assign int_part  = div[DIV_W-1:FRAC_W];
    assign frac_part = div[FRAC_W-1:0];

    // An integer part of zero would never tick; run it as one.
    assign int_eff = (int_part == '0) ? LEN_W'(1) : {1'b0, int_part};
    assign target  = int_eff + LEN_W'(extra);
    assign acc_sum = {1'b0, acc} + {1'b0, frac_part};
    assign tick    = run && (div_cnt >= target - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_cnt <= '0;
            acc     <= '0;
            extra   <= 1'b0;
        end else if (tick) begin
            div_cnt <= '0;
            acc     <= acc_sum[FRAC_W-1:0];
            extra   <= acc_sum[FRAC_W];
        end else if (run) begin
            div_cnt <= div_cnt + LEN_W'(1);
        end
    end

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
    parameter int CNT_W = 20,
    parameter int RES_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [RES_W-1:0] res,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q,
    output logic             wrap
);

    logic [CNT_W-1:0] top_val;

    assign top_val = ~({CNT_W{1'b1}} << res);
    assign wrap    = tick && (cnt_q == top_val);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap;
            if (tick) begin
                cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_tmr_fsm.sv
module pwm_tmr_fsm
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       pause,
    output tmr_state_e state_o,
    output logic       run,
    output logic       clear
);

    tmr_state_e state_q;
    tmr_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TMR_HOLD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_HOLD: begin
                if (!hold) state_d = pause ? TMR_PAUSE : TMR_RUN;
            end
            TMR_RUN: begin
                if (hold)       state_d = TMR_HOLD;
                else if (pause) state_d = TMR_PAUSE;
            end
            TMR_PAUSE: begin
                if (hold)        state_d = TMR_HOLD;
                else if (!pause) state_d = TMR_RUN;
            end
            default: state_d = TMR_HOLD;
        endcase
    end

    always_comb begin
        state_o = state_q;
        run     = (state_q == TMR_RUN);
        clear   = (state_q == TMR_HOLD);
    end

endmodule

// File: rtl/pwm_frac_timer.sv
module pwm_frac_timer
    import pwm_timer_pkg::*;
#(
    parameter int DIV_W  = 18,
    parameter int FRAC_W = 8,
    parameter int RES_W  = 5,
    parameter int CNT_W  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [RES_W-1:0] cfg_res,
    input  logic             cfg_pause,
    input  logic             cfg_hold,
    input  logic             cfg_upd,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             upd_pend_o
);

    logic             pause_q;
    logic             hold_q;
    logic             pend_q;
    logic [DIV_W-1:0] act_div;
    logic [RES_W-1:0] act_res;
    logic             applied;
    logic             latch_ok;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    tmr_state_e       state;
    logic             run;
    logic             clr;

    // Shadowed values move to active only at a period boundary or while held.
    assign latch_ok = (state == TMR_HOLD) | wrap;

    pwm_cfg_shadow #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W),
        .RES_W (RES_W),
        .CNT_W (CNT_W)
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wr_div    (cfg_div),
        .wr_res    (cfg_res),
        .wr_pause  (cfg_pause),
        .wr_hold   (cfg_hold),
        .wr_upd    (cfg_upd),
        .latch_ok  (latch_ok),
        .pause_q   (pause_q),
        .hold_q    (hold_q),
        .upd_pend_q(pend_q),
        .act_div   (act_div),
        .act_res   (act_res),
        .applied   (applied)
    );

    pwm_tmr_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold_q),
        .pause  (pause_q),
        .state_o(state),
        .run    (run),
        .clear  (clr)
    );

    pwm_frac_div #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .clear(clr | applied),
        .div  (act_div),
        .tick (tick)
    );

    pwm_period_cnt #(
        .CNT_W(CNT_W),
        .RES_W(RES_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clear(clr),
        .tick (tick),
        .res  (act_res),
        .cnt_q(cnt_q),
        .ovf_q(ovf_q),
        .wrap (wrap)
    );

    // Hold reads as zero from the first clock after it is written.
    assign cnt_o      = hold_q ? '0 : cnt_q;
    assign ovf_o      = ovf_q & ~hold_q;
    assign upd_pend_o = pend_q;

endmodule

// File: rtl/pwm_frac_timer_chk.sv
module pwm_frac_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int RES_W = 5,
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cnt_o,
    input logic             ovf_o,
    input logic             upd_pend_o,
    input tmr_state_e       state,
    input logic [RES_W-1:0] act_res,
    input logic             clr
);

    logic [CNT_W-1:0] mask_now;
    assign mask_now = ~({CNT_W{1'b1}} << act_res);

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (state == TMR_PAUSE) |=> (cnt_q == $past(cnt_q))); // R10

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (cnt_o == '0)); // R6

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> !ovf_o); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q != $past(cnt_q)) && !$past(clr))
        |-> (cnt_q == (($past(cnt_q) + CNT_W'(1)) & $past(mask_now)))); // R5

    AST_PEND_DROP_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_pend_o) |-> (cnt_o == '0)); // R7

    AST_RES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (act_res != '0) && (act_res <= RES_W'(CNT_W))); // R5

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state == TMR_HOLD) |=> (cnt_q == '0)); // R9

endmodule

bind pwm_frac_timer pwm_frac_timer_chk #(
    .RES_W(RES_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_q     (cnt_q),
    .cnt_o     (cnt_o),
    .ovf_o     (ovf_o),
    .upd_pend_o(upd_pend_o),
    .state     (state),
    .act_res   (act_res),
    .clr       (clr)
);

// File: tb/pwm_frac_timer_tb.sv
module pwm_frac_timer_tb;

    localparam int DIV_W  = 18;
    localparam int FRAC_W = 8;
    localparam int RES_W  = 5;
    localparam int CNT_W  = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [RES_W-1:0] cfg_res = '0;
    logic             cfg_pause = 1'b0;
    logic             cfg_hold = 1'b1;
    logic             cfg_upd = 1'b0;
    logic [CNT_W-1:0] cnt_o;
    logic             ovf_o;
    logic             upd_pend_o;

    always #10 clk = ~clk;

    pwm_frac_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_div   (cfg_div),
        .cfg_res   (cfg_res),
        .cfg_pause (cfg_pause),
        .cfg_hold  (cfg_hold),
        .cfg_upd   (cfg_upd),
        .cnt_o     (cnt_o),
        .ovf_o     (ovf_o),
        .upd_pend_o(upd_pend_o)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    bit    mon_en = 1'b0;
    string cur_req = "R2";
    int    exp_val[$];
    int    exp_gap[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int top_of(input int res);
        int r;
        r = (res == 0) ? 1 : res;
        return (1 << r) - 1;
    endfunction

    // Scoreboard producer: expected values and interval lengths from the R3 accumulator rule.
    task automatic push_seq(input int start, input int div, input int top,
                            input int n, input bit first_dc);
        int v;
        int acc;
        int extra;
        int ieff;
        v     = start;
        acc   = 0;
        extra = 0;
        ieff  = ((div >> 8) == 0) ? 1 : (div >> 8);
        for (int k = 0; k < n; k++) begin
            v = (v == top) ? 0 : v + 1;
            exp_val.push_back(v);
            exp_gap.push_back((k == 0 && first_dc) ? -1 : ieff + extra);
            acc   = acc + (div & 255);
            extra = acc >> 8;
            acc   = acc & 255;
        end
    endtask

    task automatic cfg_write(input int div, input int res, input bit pause,
                             input bit hold, input bit upd);
        cfg_div   = DIV_W'(div);
        cfg_res   = RES_W'(res);
        cfg_pause = pause;
        cfg_hold  = hold;
        cfg_upd   = upd;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we  = 1'b0;
        cfg_upd = 1'b0;
    endtask

    task automatic drain();
        while (exp_val.size() != 0) @(negedge clk);
    endtask

    task automatic restart(input int div, input int res, input int n);
        mon_en = 1'b0;
        exp_val.delete();
        exp_gap.delete();
        cfg_write(div, res, 1'b0, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check(upd_pend_o == 1'b0, "R9", "update pending while held", upd_pend_o, 0);
        check(cnt_o == '0, "R9", "count while held", cnt_o, 0);
        push_seq(0, div, top_of(res), n, 1'b1);
        mon_en = 1'b1;
        cfg_write(div, res, 1'b0, 1'b0, 1'b0);
    endtask

    // Scoreboard consumer: compares each count change against the queue.
    initial begin
        int prev;
        int gap;
        int v;
        int g;
        prev = 0;
        gap  = 0;
        forever begin
            @(negedge clk);
            gap++;
            if (int'(cnt_o) != prev) begin
                if (mon_en) begin
                    if (exp_val.size() == 0) begin
                        check(1'b0, "R5", "unexpected count change", cnt_o, prev);
                    end else begin
                        v = exp_val.pop_front();
                        g = exp_gap.pop_front();
                        check(int'(cnt_o) == v, "R5", "count value", cnt_o, v);
                        if (g >= 0) check(gap == g, cur_req, "tick interval", gap, g);
                        check(ovf_o == (v == 0), "R6", "overflow at change", ovf_o, v == 0);
                    end
                end
                gap  = 0;
                prev = int'(cnt_o);
            end else if (mon_en && ovf_o) begin
                check(1'b0, "R6", "overflow without wrap", 1, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int  cur;
        int  v;
        bit  ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values and default hold
        ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (cnt_o != '0 || ovf_o || upd_pend_o) ok = 1'b0;
        end
        check(ok, "R1", "outputs idle after reset", cnt_o, 0);
        check(upd_pend_o == 1'b0, "R1", "update bit after reset", upd_pend_o, 0);

        // R2: integer divide by 4, resolution 2
        cur_req = "R2";
        restart(4 << 8, 2, 12);
        drain();

        // R8: new values without the update bit change nothing
        cur_req = "R8";
        @(negedge clk);
        cur = int'(cnt_o);
        cfg_write(6 << 8, 3, 1'b0, 1'b0, 1'b0);
        check(upd_pend_o == 1'b0, "R8", "no pending update", upd_pend_o, 0);
        push_seq(cur, 4 << 8, 3, 8, 1'b1);
        drain();

        // R7: deferred update applied at the wrap
        cur_req = "R7";
        @(negedge clk);
        cur = int'(cnt_o);
        cfg_write(2 << 8, 3, 1'b0, 1'b0, 1'b1);
        check(upd_pend_o == 1'b1, "R7", "update bit readback", upd_pend_o, 1);
        push_seq(cur, 4 << 8, 3, 3 - cur + 1, 1'b1);
        push_seq(0, 2 << 8, 7, 10, 1'b0);
        while (upd_pend_o) @(negedge clk);
        check(cnt_o == '0, "R7", "count when update lands", cnt_o, 0);
        check(ovf_o == 1'b1, "R7", "overflow when update lands", ovf_o, 1);
        drain();

        // R3: divisor 2.5
        cur_req = "R3";
        restart(2 * 256 + 128, 3, 20);
        drain();

        // R4: divisor 0.25 runs as integer part 1
        cur_req = "R4";
        restart(64, 2, 20);
        drain();

        // R5: resolution 0 counts as 1 bit
        cur_req = "R5";
        restart(2 << 8, 0, 8);
        drain();

        // R10: pause and resume
        restart(4 << 8, 4, 6);
        drain();
        mon_en = 1'b0;
        cfg_write(4 << 8, 4, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        v  = int'(cnt_o);
        ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (int'(cnt_o) != v) ok = 1'b0;
        end
        check(ok, "R10", "count frozen while paused", cnt_o, v);
        cfg_write(4 << 8, 4, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 30 && int'(cnt_o) == v; i++) @(negedge clk);
        check(int'(cnt_o) == ((v + 1) & 15), "R10", "value after resume", cnt_o, (v + 1) & 15);

        // R9: hold while running
        cfg_write(4 << 8, 4, 1'b0, 1'b1, 1'b0);
        check(cnt_o == '0, "R9", "count right after hold", cnt_o, 0);
        ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (cnt_o != '0 || ovf_o) ok = 1'b0;
        end
        check(ok, "R9", "count stays zero while held", cnt_o, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule